// File: doc/BRIEF.md
# Fault Consequent Action and AIS Controller

This block handles alarms for a four-tributary, fourth-order digital multiplexer/demultiplexer pair. It takes the fault flags that other logic has already detected: power failure, loss of each tributary input, loss of the aggregate input, loss of frame, and an alarm received from the far end. It turns them into the actions each fault requires. These actions are a prompt maintenance alarm, the outgoing far-end alarm bit, all-ones substitution (AIS) on the demultiplexer tributary outputs, AIS on the whole aggregate output, and AIS in the time slots of a lost tributary. When several faults are present at the same time, the outputs are the OR of the actions that each fault asks for.

The block also watches the incoming aggregate bit stream for AIS. An external framer marks the last bit of each frame and reports whether the alignment word was found. A frame with fewer than `ZERO_THR` zeros and no alignment word declares AIS. A frame with more than `ZERO_THR` zeros clears it. Any other frame leaves the state as it is. While AIS is detected, the maintenance alarm that loss of frame would raise is held off. The other loss-of-frame actions still apply.

All action outputs are registered and change only on the multiplexer frame strobe. For a tributary whose slots carry AIS, the block also supplies a justification decision per frame. It justifies in `JUST_NUM` out of every `JUST_DEN` frames, so the AIS rate stays at nominal.

Top module: `fault_action_ctrl`

## Requirements
- R1: After reset, every output is 0.
- R2: The action outputs (maint_alarm, tx_rai, dmx_ais, agg_ais, slot_ais, far_fault) change only in the clock cycle after a cycle where frm_tick is 1. At that edge they take values computed from the fault inputs of that cycle.
- R3: tx_rai, the value sent in the far-end alarm bit (bit 13 of group I), is 1 when pwr_fail, agg_los or lof is set. Otherwise it is 0.
- R4: All bits of dmx_ais are 1 when pwr_fail, agg_los or lof is set.
- R5: agg_ais is 1 only for pwr_fail.
- R6: slot_ais[i] follows trib_los[i] only. A tributary loss sets neither tx_rai nor dmx_ais.
- R7: maint_alarm is 1 when pwr_fail, agg_los, or any trib_los bit is set. lof also sets it, but only while rx_ais is 0.
- R8: rx_ais changes only at a valid last bit of a frame. It is set when that frame, its last bit included, held fewer than ZERO_THR zeros and rx_faw_ok was 0.
- R9: A frame with rx_faw_ok = 1 never sets rx_ais, even if every other bit is 1.
- R10: rx_ais is cleared when a frame holds more than ZERO_THR zeros. It is held when the frame holds exactly ZERO_THR zeros.
- R11: A frame with bit errors, meaning up to ZERO_THR-1 zeros, is still detected as AIS.
- R12: ais_just[i] is 1 only while slot_ais[i] is 1. Over any JUST_DEN consecutive frame strobes, it is 1 after exactly JUST_NUM of them.
- R13: rx_remote drives far_fault only. It causes no other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_tick | input | 1 | Multiplexer frame boundary strobe |
| pwr_fail | input | 1 | Power failure flag |
| trib_los | input | NTRIB | Per-tributary input signal loss |
| agg_los | input | 1 | Aggregate input signal loss |
| lof | input | 1 | Loss of frame alignment |
| rx_remote | input | 1 | Far-end alarm bit received |
| rx_vld | input | 1 | rx_bit is valid this cycle |
| rx_bit | input | 1 | Incoming aggregate data bit |
| rx_last | input | 1 | rx_bit is the last bit of a frame |
| rx_faw_ok | input | 1 | Alignment word found in this frame (read with rx_last) |
| maint_alarm | output | 1 | Prompt maintenance alarm |
| tx_rai | output | 1 | Value for the outgoing far-end alarm bit |
| dmx_ais | output | NTRIB | AIS on the demultiplexer tributary outputs |
| agg_ais | output | 1 | AIS on the whole aggregate output |
| slot_ais | output | NTRIB | AIS in a tributary's multiplexed time slots |
| ais_just | output | NTRIB | Justify this frame for an AIS tributary |
| far_fault | output | 1 | Far-end alarm indication, registered |
| rx_ais | output | 1 | Incoming aggregate AIS detected |

## Verification
The bench raises a fault between frame strobes to confirm that nothing moves mid-frame. A design that updates on every clock would show the alarm early. It feeds a frame with an alignment word but no other zeros. A detector that only counts zeros would wrongly declare AIS there. It also feeds frames with exactly ZERO_THR-1, ZERO_THR and ZERO_THR+1 zeros, so an off-by-one in the threshold, or missing hysteresis, shows up as a wrong rx_ais. With loss of frame and AIS present together, it expects the maintenance alarm to stay low while the far-end bit and tributary AIS remain set. It then counts justifications over a full JUST_DEN window, which catches a wrong ratio or justification on a healthy tributary.

// File: rtl/fault_action_ctrl.sv
module fault_action_ctrl #(
  parameter int NTRIB      = 4,
  parameter int FRAME_BITS = 2928,
  parameter int ZERO_THR   = 5,
  parameter int JUST_NUM   = 419,
  parameter int JUST_DEN   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_tick,
  input  logic             pwr_fail,
  input  logic [NTRIB-1:0] trib_los,
  input  logic             agg_los,
  input  logic             lof,
  input  logic             rx_remote,
  input  logic             rx_vld,
  input  logic             rx_bit,
  input  logic             rx_last,
  input  logic             rx_faw_ok,
  output logic             maint_alarm,
  output logic             tx_rai,
  output logic [NTRIB-1:0] dmx_ais,
  output logic             agg_ais,
  output logic [NTRIB-1:0] slot_ais,
  output logic [NTRIB-1:0] ais_just,
  output logic             far_fault,
  output logic             rx_ais
);
  localparam int ZW = $clog2(FRAME_BITS + 1);
  localparam int AW = $clog2(JUST_DEN + JUST_NUM + 1);
  localparam logic [ZW-1:0] THR_V = ZW'(ZERO_THR);
  localparam logic [AW-1:0] NUM_V = AW'(JUST_NUM);
  localparam logic [AW-1:0] DEN_V = AW'(JUST_DEN);

  // incoming AIS detector
  logic [ZW-1:0] zcnt;
  wire  [ZW-1:0] ztot = zcnt + {{(ZW-1){1'b0}}, ~rx_bit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zcnt   <= '0;
      rx_ais <= 1'b0;
    end else if (rx_vld) begin
      if (rx_last) begin
        zcnt <= '0;
        if (ztot < THR_V && !rx_faw_ok) rx_ais <= 1'b1;
        else if (ztot > THR_V)          rx_ais <= 1'b0;
      end else begin
        zcnt <= ztot;
      end
    end
  end

  // consequent actions
  wire line_flt = pwr_fail | agg_los | lof;
  wire maint_n  = pwr_fail | agg_los | (|trib_los) | (lof & ~rx_ais);

  logic [AW-1:0] acc;
  logic          just_r;
  wire  [AW-1:0] acc_sum = acc + NUM_V;
  wire           just_n  = acc_sum >= DEN_V;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maint_alarm <= 1'b0;
      tx_rai      <= 1'b0;
      dmx_ais     <= '0;
      agg_ais     <= 1'b0;
      slot_ais    <= '0;
      far_fault   <= 1'b0;
      acc         <= '0;
      just_r      <= 1'b0;
    end else if (frm_tick) begin
      maint_alarm <= maint_n;
      tx_rai      <= line_flt;
      dmx_ais     <= {NTRIB{line_flt}};
      agg_ais     <= pwr_fail;
      slot_ais    <= trib_los;
      far_fault   <= rx_remote;
      acc         <= just_n ? acc_sum - DEN_V : acc_sum;
      just_r      <= just_n;
    end
  end

  assign ais_just = slot_ais & {NTRIB{just_r}};

  assert_hold_midframe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_tick |=> $stable({maint_alarm, tx_rai, dmx_ais, agg_ais, slot_ais, far_fault}));

  assert_power_actions_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_tick && pwr_fail |=> agg_ais && tx_rai && (&dmx_ais) && maint_alarm);

  assert_detect_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_vld && rx_last) |=> $stable(rx_ais));

  assert_faw_not_ais_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld && rx_last && rx_faw_ok && !rx_ais |=> !rx_ais);

  assert_lof_suppressed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_tick && lof && rx_ais && !pwr_fail && !agg_los && (trib_los == '0) |=> !maint_alarm && tx_rai);

  assert_acc_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc < DEN_V);
endmodule

// File: tb/tb_fault_action_ctrl.sv
module tb_fault_action_ctrl;
  localparam int CLK_P = 10;
  localparam int NT = 4;
  localparam int FB = 2928;
  localparam int THR = 5;

  logic clk = 0, rst_n = 0, frm_tick = 0, pwr_fail = 0, agg_los = 0, lof = 0;
  logic rx_remote = 0, rx_vld = 0, rx_bit = 1, rx_last = 0, rx_faw_ok = 0;
  logic [NT-1:0] trib_los = '0;
  logic maint_alarm, tx_rai, agg_ais, far_fault, rx_ais;
  logic [NT-1:0] dmx_ais, slot_ais, ais_just;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fault_action_ctrl #(.NTRIB(NT), .FRAME_BITS(FB), .ZERO_THR(THR)) dut (
    .clk(clk), .rst_n(rst_n), .frm_tick(frm_tick), .pwr_fail(pwr_fail),
    .trib_los(trib_los), .agg_los(agg_los), .lof(lof), .rx_remote(rx_remote),
    .rx_vld(rx_vld), .rx_bit(rx_bit), .rx_last(rx_last), .rx_faw_ok(rx_faw_ok),
    .maint_alarm(maint_alarm), .tx_rai(tx_rai), .dmx_ais(dmx_ais), .agg_ais(agg_ais),
    .slot_ais(slot_ais), .ais_just(ais_just), .far_fault(far_fault), .rx_ais(rx_ais));

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) frm_tick = 1;
    @(negedge clk) frm_tick = 0;
  endtask

  task automatic send_frame(input int zeros, input bit faw);
    for (int i = 0; i < FB; i++) begin
      @(negedge clk);
      rx_vld = 1; rx_bit = (i < zeros) ? 1'b0 : 1'b1;
      rx_last = (i == FB-1); rx_faw_ok = faw && (i == FB-1);
    end
    @(negedge clk);
    rx_vld = 0; rx_last = 0; rx_faw_ok = 0; rx_bit = 1;
  endtask

  task automatic t_reset();
    chk({maint_alarm, tx_rai, dmx_ais, agg_ais, slot_ais, ais_just, far_fault, rx_ais}, 0, "R1 reset");
  endtask

  task automatic t_power();
    pwr_fail = 1;
    repeat (5) @(negedge clk);
    chk({agg_ais, tx_rai, maint_alarm, dmx_ais}, 0, "R2 no change mid-frame");
    tick();
    chk(agg_ais, 1, "R5 agg ais on power");
    chk(tx_rai, 1, "R3 rai on power");
    chk(dmx_ais, 4'hF, "R4 dmx ais on power");
    chk(maint_alarm, 1, "R7 maint on power");
    pwr_fail = 0;
    repeat (3) @(negedge clk);
    chk(agg_ais, 1, "R2 hold until tick");
    tick();
    chk({maint_alarm, tx_rai, dmx_ais, agg_ais}, 0, "R2 cleared at tick");
  endtask

  task automatic t_trib();
    int cnt[NT];
    trib_los = 4'b0100;
    tick();
    chk(slot_ais, 4'b0100, "R6 slot ais");
    chk({tx_rai, dmx_ais, agg_ais}, 0, "R6 no line actions");
    chk(maint_alarm, 1, "R7 maint on trib loss");
    for (int k = 0; k < NT; k++) cnt[k] = 0;
    for (int n = 0; n < 1000; n++) begin
      tick();
      for (int k = 0; k < NT; k++) cnt[k] += int'(ais_just[k]);
    end
    chk(cnt[2], 419, "R12 justify ratio");
    chk(cnt[0] + cnt[1] + cnt[3], 0, "R12 no justify on healthy");
    trib_los = 0;
    tick();
    chk({slot_ais, ais_just, maint_alarm}, 0, "R6 slot ais cleared");
  endtask

  task automatic t_agg();
    agg_los = 1;
    tick();
    chk(tx_rai, 1, "R3 rai on agg loss");
    chk(dmx_ais, 4'hF, "R4 dmx ais on agg loss");
    chk(agg_ais, 0, "R5 no agg ais on agg loss");
    agg_los = 0;
    tick();
  endtask

  task automatic t_detect();
    send_frame(0, 1);
    chk(rx_ais, 0, "R9 faw frame not ais");
    send_frame(THR, 0);
    chk(rx_ais, 0, "R10 threshold holds clear");
    send_frame(THR-1, 0);
    chk(rx_ais, 1, "R11 ais with errors");
    send_frame(THR, 0);
    chk(rx_ais, 1, "R10 threshold holds set");
    send_frame(0, 0);
    chk(rx_ais, 1, "R8 ais kept");
  endtask

  task automatic t_suppress();
    lof = 1;
    tick();
    chk(maint_alarm, 0, "R7 lof maint suppressed");
    chk(tx_rai, 1, "R3 rai on lof with ais");
    chk(dmx_ais, 4'hF, "R4 dmx ais on lof");
    send_frame(THR+1, 0);
    chk(rx_ais, 0, "R10 cleared above threshold");
    tick();
    chk(maint_alarm, 1, "R7 lof maint restored");
    lof = 0;
    tick();
  endtask

  task automatic t_remote();
    rx_remote = 1;
    tick();
    chk(far_fault, 1, "R13 far fault");
    chk({maint_alarm, tx_rai, dmx_ais, agg_ais, slot_ais}, 0, "R13 no other action");
    rx_remote = 0;
    tick();
    chk(far_fault, 0, "R13 far fault cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_power();
    t_trib();
    t_agg();
    t_detect();
    t_suppress();
    t_remote();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule